// File: doc/BRIEF.md
# FSK Edge-Interval Demodulator with Run-to-Bit Aggregation

This block turns a stream of 8-bit envelope samples, one per carrier cycle, into a stream of data bits for a two-tone FSK link. Every accepted sample is sliced to a binary level against a fixed threshold. The block measures the spacing between successive low-to-high crossings and labels each spacing as the fast tone or the slow tone. Spacing is compared, not tone energy.

Consecutive equal tone labels form a run. When the label changes, the finished run is turned into a number of data bits. The divisor used depends on whether the run held fast-tone or slow-tone labels, and runs that come out too long are dropped. The bits are then replayed one per clock with a valid strobe. The two divisors and the run ceiling are inputs, so one instance serves card formats with different bit timings. A flush input closes the pending run and restarts the stream.

Top module: `fsk_gap_demod`

## Requirements
- R1: Synchronous reset clears the slicer history, the interval counter, the run state and any queued bits. `bit_valid` is 0 while reset is held and in the first cycle after it. A run that is pending when reset is applied is never emitted.
- R2: An accepted sample with value 127 or more is level 1. A value of 126 or less is level 0.
- R3: On each accepted sample whose level is 1 while the previous accepted sample was 0, the distance in samples from the previous such crossing is classified. A distance below 9 gives symbol 1 and any larger distance gives symbol 0. The first crossing is measured from sample position 0 of the stream. The distance counter saturates at 255.
- R4: The first run of a stream counts every symbol in it. After each symbol change the count restarts at 0, so every later run counts one fewer than its symbol count. The count saturates at 255.
- R5: When a run closes, its bit count is (count+1)/`cfg_d1` for a run of symbol 1 and (count+1)/`cfg_d0` for a run of symbol 0, using integer division. A result of 0 becomes 1. A divisor of 0 acts as 1.
- R6: A run whose bit count is not less than `cfg_max` emits nothing, so `cfg_max` = 0 silences the output.
- R7: A kept run emits its symbol value as `bit_out`, once per bit of its count. The bits come on consecutive `bit_valid` cycles, at most one per clock, and runs come out in the order they closed.
- R8: The last run stays pending until a symbol change or a `flush`. A `flush` closes the pending run under R5 and R6 and then restarts the stream at sample position 0. A sample presented in the same cycle as `flush` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample | input | 8 | Envelope sample |
| sample_valid | input | 1 | Accept `sample` this cycle |
| flush | input | 1 | Close pending run and restart stream |
| cfg_d1 | input | 8 | Divisor for runs of symbol 1 |
| cfg_d0 | input | 8 | Divisor for runs of symbol 0 |
| cfg_max | input | 8 | Bit-count ceiling; counts at or above it are dropped |
| bit_out | output | 1 | Emitted data bit |
| bit_valid | output | 1 | `bit_out` holds a bit this cycle |

## Verification
The hardest case to reach from the ports is the pair of run-count quirks. The first run counts all of its symbols while every later run counts one fewer, and a conversion that lands exactly on `cfg_max` must be dropped. Both depend on the symbol sequence, which can only be set up through waveform shape. The stimulus builds square waves with chosen periods, including 8 against 9 samples at the classification edge. It uses divisors of 1 and 0 so that every run length shows up directly in the output. The `cfg_max` settings place conversions right at the ceiling. A long low dropout drives the interval counter into saturation, and a flush issued together with a sample checks that the sample is dropped.

// File: rtl/fsk_gap_demod.sv
module fsk_gap_demod #(
  parameter int SW         = 8,
  parameter int CFGW       = 8,
  parameter int CW         = 8,
  parameter int RW         = 8,
  parameter int THRESH     = 127,
  parameter int FAST_LIMIT = 9,
  parameter int DEPTH      = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SW-1:0]   sample,
  input  logic            sample_valid,
  input  logic            flush,
  input  logic [CFGW-1:0] cfg_d1,
  input  logic [CFGW-1:0] cfg_d0,
  input  logic [CFGW-1:0] cfg_max,
  output logic            bit_out,
  output logic            bit_valid
);
  localparam int QW = (RW + 1 > CFGW) ? RW + 1 : CFGW;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] GAP_TOP = '1;
  localparam logic [RW-1:0] RUN_TOP = '1;

  logic          started_q, prev_q, have_q, sym_q;
  logic [CW-1:0] gap_q;
  logic [RW-1:0] run_q;

  logic level_now, take, edge_hit, sym_new, change, close_run;
  assign level_now = sample >= SW'(THRESH);
  assign take      = sample_valid && !flush;
  assign edge_hit  = take && started_q && !prev_q && level_now;
  assign sym_new   = gap_q < CW'(FAST_LIMIT);
  assign change    = edge_hit && have_q && (sym_new != sym_q);
  assign close_run = change || (flush && have_q);

  logic [CFGW-1:0] div_sel, div_eff;
  logic [QW-1:0]   quo, nbits;
  logic            keep, push;
  assign div_sel = sym_q ? cfg_d1 : cfg_d0;
  assign div_eff = (div_sel == '0) ? CFGW'(1) : div_sel;
  assign quo     = (QW'(run_q) + QW'(1)) / QW'(div_eff);
  assign nbits   = (quo == '0) ? QW'(1) : quo;
  assign keep    = nbits < QW'(cfg_max);
  assign push    = close_run && keep;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      started_q <= 1'b0;
      prev_q    <= 1'b0;
      gap_q     <= '0;
      have_q    <= 1'b0;
      sym_q     <= 1'b0;
      run_q     <= '0;
    end else if (sample_valid) begin
      started_q <= 1'b1;
      prev_q    <= level_now;
      if (edge_hit) begin
        gap_q <= CW'(1);
        if (!have_q) begin
          have_q <= 1'b1;
          sym_q  <= sym_new;
          run_q  <= RW'(1);
        end else if (sym_new == sym_q) begin
          run_q <= (run_q == RUN_TOP) ? run_q : run_q + 1'b1;
        end else begin
          sym_q <= sym_new;
          run_q <= '0;
        end
      end else begin
        gap_q <= (gap_q == GAP_TOP) ? gap_q : gap_q + 1'b1;
      end
    end
  end

  logic          val_mem [DEPTH];
  logic [QW-1:0] cnt_mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] level_q;
  logic [QW-1:0] used_q;
  logic          busy, pop, push_ok;

  assign busy    = level_q != '0;
  assign pop     = busy && (used_q + QW'(1) == cnt_mem[rd_q]);
  assign push_ok = push && ((level_q != LW'(DEPTH)) || pop);

  always_ff @(posedge clk) begin
    if (push_ok) begin
      val_mem[wr_q] <= sym_q;
      cnt_mem[wr_q] <= nbits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q      <= '0;
      rd_q      <= '0;
      level_q   <= '0;
      used_q    <= '0;
      bit_valid <= 1'b0;
      bit_out   <= 1'b0;
    end else begin
      if (push_ok) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)     rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      level_q   <= level_q + LW'(push_ok) - LW'(pop);
      used_q    <= pop ? '0 : (busy ? used_q + QW'(1) : used_q);
      bit_valid <= busy;
      bit_out   <= busy ? val_mem[rd_q] : 1'b0;
    end
  end
endmodule

module fsk_gap_demod_chk #(
  parameter int CW    = 8,
  parameter int LW    = 3,
  parameter int DEPTH = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          sample_valid,
  input logic          flush,
  input logic          edge_hit,
  input logic [CW-1:0] gap_q,
  input logic [LW-1:0] level_q,
  input logic          bit_valid
);
  localparam logic [CW-1:0] TOP = '1;

  p_quiet_after_reset_r1: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> !bit_valid);

  p_gap_saturates_r3: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && !flush && !edge_hit && gap_q == TOP) |=> gap_q == TOP);

  p_gap_restarts_r3: assert property (@(posedge clk) disable iff (rst)
    (edge_hit && !flush) |=> gap_q == CW'(1));

  p_queue_bounded_r7: assert property (@(posedge clk) disable iff (rst)
    level_q <= LW'(DEPTH));

  p_valid_needs_queue_r7: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> $past(level_q) != '0);

  p_flush_restarts_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> gap_q == '0);
endmodule

bind fsk_gap_demod fsk_gap_demod_chk #(.CW(CW), .LW(LW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .sample_valid(sample_valid), .flush(flush),
  .edge_hit(edge_hit), .gap_q(gap_q), .level_q(level_q), .bit_valid(bit_valid)
);

// File: tb/fsk_gap_demod_bench.sv
module fsk_gap_demod_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] sample = '0;
  logic sample_valid = 1'b0, flush = 1'b0;
  logic [7:0] cfg_d1 = 8'd6, cfg_d0 = 8'd5, cfg_max = 8'd5;
  logic bit_out, bit_valid;

  always #10 clk = ~clk;

  fsk_gap_demod u_fsk_gap_demod (
    .clk(clk), .rst(rst), .sample(sample), .sample_valid(sample_valid),
    .flush(flush), .cfg_d1(cfg_d1), .cfg_d0(cfg_d0), .cfg_max(cfg_max),
    .bit_out(bit_out), .bit_valid(bit_valid)
  );

  int n_checks = 0, n_fail = 0, obs = 0;
  int exp_q[$];
  string tag_q[$];
  string cur_tag = "R7";
  int m_idx, m_last, m_prev, m_have, m_sym, m_n;
  int c_d1, c_d0, c_max;
  int unsigned seed = 32'd12345;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic m_clear();
    m_idx = 0; m_last = 0; m_prev = 0; m_have = 0; m_sym = 0; m_n = 0;
  endtask

  task automatic m_emit(input int v, input int n);
    int d, q;
    d = v ? c_d1 : c_d0;
    if (d == 0) d = 1;
    q = (n + 1) / d;
    if (q == 0) q = 1;
    if (q < c_max)
      for (int k = 0; k < q; k++) begin exp_q.push_back(v); tag_q.push_back(cur_tag); end
  endtask

  task automatic m_sample(input int s);
    int b, sym;
    b = (s >= 127) ? 1 : 0;
    if (m_idx > 0 && m_prev == 0 && b == 1) begin
      sym = ((m_idx - m_last) < 9) ? 1 : 0;
      m_last = m_idx;
      if (!m_have) begin m_have = 1; m_sym = sym; m_n = 1; end
      else if (sym == m_sym) m_n++;
      else begin m_emit(m_sym, m_n); m_n = 0; m_sym = sym; end
    end
    m_prev = b;
    m_idx++;
  endtask

  always @(negedge clk) begin
    if (!rst && bit_valid) begin
      obs++;
      if (exp_q.size() == 0) check(1'b0, "R7 unexpected bit", int'(bit_out), -1);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(bit_out) == e, t, int'(bit_out), e);
      end
    end
  end

  task automatic set_cfg(input int d1, input int d0, input int mx);
    @(posedge clk); #2;
    cfg_d1 = 8'(d1); cfg_d0 = 8'(d0); cfg_max = 8'(mx);
    c_d1 = d1; c_d0 = d0; c_max = mx;
  endtask

  task automatic put(input int s);
    @(posedge clk); #2;
    sample = 8'(s); sample_valid = 1'b1;
    m_sample(s);
    @(posedge clk); #2;
    sample_valid = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic tone(input int per, input int reps, input int lo, input int hi);
    for (int r = 0; r < reps; r++)
      for (int i = 0; i < per; i++) put((i < per - per / 2) ? lo : hi);
  endtask

  task automatic do_flush(input bit with_sample);
    @(posedge clk); #2;
    flush = 1'b1;
    if (with_sample) begin sample = 8'd255; sample_valid = 1'b1; end
    if (m_have) m_emit(m_sym, m_n);
    m_clear();
    @(posedge clk); #2;
    flush = 1'b0; sample_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    repeat (300) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
  endtask

  task automatic do_reset();
    @(posedge clk); #2; rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bit_valid == 1'b0, "R1 valid low in reset", int'(bit_valid), 0);
    @(posedge clk); #2; rst = 1'b0;
    m_clear();
    @(negedge clk);
    check(bit_valid == 1'b0, "R1 valid low after reset", int'(bit_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int base;
    c_d1 = 6; c_d0 = 5; c_max = 5;
    m_clear();
    do_reset();

    cur_tag = "R5 format 6/5/5";
    tone(8, 12, 0, 255); tone(10, 10, 0, 255); tone(8, 6, 0, 255);
    tone(10, 5, 0, 255); tone(8, 18, 0, 255); tone(10, 15, 0, 255);
    do_flush(1'b0); drain("R7 format A drained");

    set_cfg(7, 6, 13);
    cur_tag = "R4 format 7/6/13";
    for (int seg = 0; seg < 20; seg++) begin
      int per, reps;
      seed = seed * 1103515245 + 12345;
      per = 7 + int'((seed >> 16) % 5);
      seed = seed * 1103515245 + 12345;
      reps = 1 + int'((seed >> 16) % 12);
      tone(per, reps, 0, 255);
    end
    do_flush(1'b0); drain("R7 format B drained");

    set_cfg(1, 1, 255);
    cur_tag = "R2 slice 126/127";
    tone(8, 3, 126, 127); tone(12, 4, 126, 127); tone(8, 2, 126, 127);
    do_flush(1'b0); drain("R2 boundary drained");
    base = obs;
    tone(8, 6, 0, 126); tone(12, 6, 0, 126);
    do_flush(1'b0); drain("R2 no-edge drained");
    check(obs == base, "R2 126 never level 1", obs - base, 0);

    cur_tag = "R3 spacing 8 vs 9";
    tone(8, 3, 0, 255); tone(9, 2, 0, 255); tone(8, 1, 0, 255);
    tone(9, 4, 0, 255); tone(8, 2, 0, 255);
    do_flush(1'b0); drain("R3 boundary drained");

    cur_tag = "R3 dropout saturation";
    tone(8, 4, 0, 255);
    for (int i = 0; i < 300; i++) put(0);
    tone(8, 3, 0, 255);
    do_flush(1'b0); drain("R3 dropout drained");

    set_cfg(1, 1, 0);
    base = obs;
    tone(8, 4, 0, 255); tone(10, 4, 0, 255); tone(8, 2, 0, 255);
    do_flush(1'b0); drain("R6 silent drained");
    check(obs == base, "R6 cfg_max 0 emits nothing", obs - base, 0);
    set_cfg(1, 1, 4);
    cur_tag = "R6 ceiling";
    tone(8, 3, 0, 255); tone(10, 4, 0, 255); tone(8, 3, 0, 255);
    tone(10, 5, 0, 255); tone(8, 1, 0, 255);
    do_flush(1'b0); drain("R6 ceiling drained");

    set_cfg(0, 2, 255);
    cur_tag = "R5 zero divisor";
    tone(8, 5, 0, 255); tone(10, 3, 0, 255); tone(8, 2, 0, 255); tone(10, 1, 0, 255);
    do_flush(1'b0); drain("R5 zero divisor drained");

    set_cfg(1, 1, 255);
    cur_tag = "R8 pending and flush";
    tone(8, 4, 0, 255); tone(10, 3, 0, 255);
    drain("R8 pending run held");
    base = obs;
    do_flush(1'b1);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(obs - base == 3, "R8 flush emits pending run", obs - base, 3);
    tone(8, 3, 0, 255); tone(12, 2, 0, 255);
    do_flush(1'b0); drain("R8 restart drained");

    cur_tag = "R1 after reset";
    tone(8, 4, 0, 255); tone(10, 3, 0, 255);
    drain("R1 pre-reset drained");
    base = obs;
    do_reset();
    repeat (20) @(posedge clk);
    check(obs == base, "R1 pending run discarded", obs - base, 0);
    tone(10, 3, 0, 255); tone(8, 2, 0, 255);
    do_flush(1'b0); drain("R1 restart drained");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule